// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side data path of a memory-mapped serial port. Characters arrive from the deserializer as 12-bit entries: eight data bits with four line-error bits above them. They are stored in a small circular buffer addressed by a read position and an occupancy count. Software drains the buffer through data-register reads. The block produces the receive-related bits of the flag register and holds a receive-status byte that carries the error bits of the last character read. It also exports the current count to the interrupt logic.

A line-control bit selects between two modes. In buffered mode the buffer is used to its full depth. In single-character mode the full flag is raised as soon as one character has arrived. Any line-control write that flips the mode bit flushes the buffer. A byte that arrives while the buffer holds sixteen entries is discarded and reported with a one-cycle overrun pulse. Stored data is never overwritten.

Top module: `uart_rx_buffer`

## Requirements
- R1: The buffer holds 16 entries and `count` stays in 0..16. An accepted byte is stored at slot (read position + count) mod 16, and bytes come out in arrival order, including across the wrap from slot 15 to slot 0.
- R2: `flags` bit 7 (transmit empty) always reads 1, bit 6 is receive-full, bit 4 is receive-empty, and bits 5 and 3..0 read 0. After reset `flags` is 0x90 and `count` is 0.
- R3: Every accepted byte clears receive-empty in the following cycle.
- R4: An accepted byte sets receive-full when line-control bit 4 is 0 (single-character mode, the mode after reset), or when it brings the count to 16 while bit 4 is 1 (buffered mode). A read strobe clears receive-full, unless a byte is accepted in the same cycle.
- R5: `rd_data` always shows the entry at the read position. A read strobe while count is nonzero decrements the count and advances the position modulo 16. A read that leaves the count at zero sets receive-empty.
- R6: A read strobe while the count is zero leaves the count, the position and the flags unchanged, and `rd_data` keeps showing the stale entry at that position.
- R7: Every read strobe loads `rx_status` with bits 11..8 of the entry shown on `rd_data` in that cycle. A `rsr_wr` pulse clears `rx_status` and takes priority over a read in the same cycle.
- R8: A line-control write whose bit 4 differs from the current mode resets the count and the position to 0, sets receive-empty, clears receive-full and discards a byte arriving in that cycle. A line-control write that keeps bit 4 leaves the buffer untouched.
- R9: A byte arriving while the count is 16 is dropped, nothing stored changes, and `overrun` is high for exactly the following cycle.
- R10: A byte and a read strobe in the same cycle, with the count between 1 and 15, both take effect, so the count is unchanged and the position advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer presents a character this cycle |
| rx_data | input | 12 | Character: data in bits 7..0, error bits in 11..8 |
| rd_strobe | input | 1 | Data-register read this cycle |
| lcr_wr | input | 1 | Line-control register write |
| lcr_wdata | input | 8 | Line-control write value; bit 4 selects buffered mode |
| rsr_wr | input | 1 | Write to receive-status register (clears it) |
| rd_data | output | 12 | Entry at the read position |
| flags | output | 8 | Flag bits: 7 tx empty, 6 rx full, 4 rx empty |
| rx_status | output | 4 | Error bits of the last character read |
| count | output | 5 | Occupancy, to the interrupt logic |
| overrun | output | 1 | One-cycle pulse for a dropped byte |

## Verification
A wrong pointer or a wrong count shows on the next clock in one of two ways. `count` leaves the sequence the reference expects, or `rd_data` shows an entry other than the oldest undrained one. The reference model therefore compares all outputs after every edge. It covers the stale-read case and the wrap past slot 15. A flag that fails to follow a mode flush, an overflow, or a read and receive in the same cycle is caught on the first edge after the event, because the flags and the overrun pulse come straight from registers.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
   localparam int FLAG_W      = 8;
   localparam int FLAG_TXE    = 7;
   localparam int FLAG_RXFULL = 6;
   localparam int FLAG_RXEMP  = 4;

   typedef struct packed {
      logic full;
      logic empty;
   } rxb_flag_t;

   function automatic logic [FLAG_W-1:0] pack_flags(rxb_flag_t f);
      logic [FLAG_W-1:0] v;
      v = '0;
      v[FLAG_TXE]    = 1'b1;
      v[FLAG_RXFULL] = f.full;
      v[FLAG_RXEMP]  = f.empty;
      return v;
   endfunction
endpackage

// File: rtl/uart_rxb_store.sv
module uart_rxb_store #(
   parameter int DEPTH     = 16,
   parameter int ENT_W     = 12,
   parameter bit CLR_RESET = 1'b1,
   parameter int AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [AW-1:0]    rd_idx,
   output logic [ENT_W-1:0] rd_data
);
   logic [ENT_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (CLR_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot[i] <= '0;
            else if (wr_en && (wr_idx == AW'(i)))
               slot[i] <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == AW'(i)))
               slot[i] <= wr_data;
         end
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/uart_rxb_ctrl.sv
module uart_rxb_ctrl
   import uart_rxb_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int MODE_BIT = 4,
   parameter int AW       = $clog2(DEPTH),
   parameter int CW       = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic          rd_strobe,
   input  logic          lcr_wr,
   input  logic [7:0]    lcr_wdata,
   output logic          wr_en,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [CW-1:0] count,
   output rxb_flag_t     flag_q,
   output logic          overrun,
   output logic          mode_q
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [AW-1:0] pos_q, pos_d;
   logic [CW-1:0] cnt_q, cnt_d;
   rxb_flag_t     flag_d;
   logic          ovr_q;
   logic          flip, accept, pop;

   assign flip   = lcr_wr && (lcr_wdata[MODE_BIT] != mode_q);
   assign accept = rx_valid && !flip && (cnt_q != FULL_CNT);
   assign pop    = rd_strobe && !flip && (cnt_q != '0);

   assign wr_en  = accept;
   assign wr_idx = pos_q + cnt_q[AW-1:0];
   assign rd_idx = pos_q;
   assign count  = cnt_q;
   assign overrun = ovr_q;

   always_comb begin
      pos_d  = pos_q;
      cnt_d  = cnt_q;
      flag_d = flag_q;
      if (flip) begin
         pos_d        = '0;
         cnt_d        = '0;
         flag_d.empty = 1'b1;
         flag_d.full  = 1'b0;
      end else begin
         if (pop)
            pos_d = pos_q + AW'(1);
         case ({accept, pop})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
         endcase
         if (accept && (!mode_q || (cnt_d == FULL_CNT)))
            flag_d.full = 1'b1;
         else if (rd_strobe)
            flag_d.full = 1'b0;
         if (accept)
            flag_d.empty = 1'b0;
         else if (rd_strobe && (cnt_d == '0))
            flag_d.empty = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q        <= '0;
         cnt_q        <= '0;
         flag_q.full  <= 1'b0;
         flag_q.empty <= 1'b1;
         ovr_q        <= 1'b0;
         mode_q       <= 1'b0;
      end else begin
         pos_q  <= pos_d;
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
         ovr_q  <= rx_valid && !flip && (cnt_q == FULL_CNT);
         if (lcr_wr)
            mode_q <= lcr_wdata[MODE_BIT];
      end
   end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
   import uart_rxb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter int ERR_W     = 4,
   parameter int MODE_BIT  = 4,
   parameter bit CLR_RESET = 1'b1,
   parameter int ENT_W     = DATA_W + ERR_W,
   parameter int CW        = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [ENT_W-1:0] rx_data,
   input  logic             rd_strobe,
   input  logic             lcr_wr,
   input  logic [7:0]       lcr_wdata,
   input  logic             rsr_wr,
   output logic [ENT_W-1:0] rd_data,
   output logic [7:0]       flags,
   output logic [ERR_W-1:0] rx_status,
   output logic [CW-1:0]    count,
   output logic             overrun
);
   localparam int AW = $clog2(DEPTH);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("uart_rx_buffer: DEPTH must be a power of two of at least 2");
   end
   if ((MODE_BIT < 0) || (MODE_BIT > 7)) begin : g_bad_mode
      $error("uart_rx_buffer: MODE_BIT must address the 8-bit line-control value");
   end
   if ((DATA_W < 5) || (ERR_W < 1)) begin : g_bad_width
      $error("uart_rx_buffer: DATA_W must be at least 5 and ERR_W at least 1");
   end

   logic          wr_en;
   logic [AW-1:0] wr_idx, rd_idx;
   rxb_flag_t     flag_q;
   logic          mode_q;
   logic [ERR_W-1:0] rsr_q;

   uart_rxb_ctrl #(.DEPTH(DEPTH), .MODE_BIT(MODE_BIT), .AW(AW), .CW(CW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rd_strobe (rd_strobe),
      .lcr_wr    (lcr_wr),
      .lcr_wdata (lcr_wdata),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .count     (count),
      .flag_q    (flag_q),
      .overrun   (overrun),
      .mode_q    (mode_q)
   );

   uart_rxb_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .CLR_RESET(CLR_RESET), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (rx_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rsr_q <= '0;
      else if (rsr_wr)
         rsr_q <= '0;
      else if (rd_strobe)
         rsr_q <= rd_data[ENT_W-1:DATA_W];
   end

   assign rx_status = rsr_q;
   assign flags     = pack_flags(flag_q);
endmodule

// File: rtl/uart_rxb_chk.sv
module uart_rxb_chk #(
   parameter int DEPTH    = 16,
   parameter int MODE_BIT = 4,
   parameter int ERR_W    = 4,
   parameter int CW       = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rd_strobe,
   input logic             lcr_wr,
   input logic [7:0]       lcr_wdata,
   input logic             rsr_wr,
   input logic [7:0]       flags,
   input logic [ERR_W-1:0] rx_status,
   input logic [CW-1:0]    count,
   input logic             overrun,
   input logic             mode_q
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   logic flip;
   assign flip = lcr_wr && (lcr_wdata[MODE_BIT] != mode_q);

   // R1
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R5
   a_r5_empty_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
      flags[4] == (count == '0));
   // R4
   a_r4_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && (count == FULL_CNT)) |-> flags[6]);
   // R9
   a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !flip && (count == FULL_CNT)) |=> (overrun && ($past(count) == FULL_CNT)));
   // R7
   a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rsr_wr |=> (rx_status == '0));
   // R8
   a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> ((count == '0) && flags[4] && !flags[6]));
   // R10
   a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rd_strobe && !flip && (count != '0) && (count != FULL_CNT))
      |=> $stable(count));
endmodule

bind uart_rx_buffer uart_rxb_chk #(.DEPTH(DEPTH), .MODE_BIT(MODE_BIT), .ERR_W(ERR_W), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rd_strobe (rd_strobe),
   .lcr_wr    (lcr_wr),
   .lcr_wdata (lcr_wdata),
   .rsr_wr    (rsr_wr),
   .flags     (flags),
   .rx_status (rx_status),
   .count     (count),
   .overrun   (overrun),
   .mode_q    (mode_q)
);

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [11:0] rx_data = '0;
   logic        rd_strobe = 1'b0;
   logic        lcr_wr = 1'b0;
   logic [7:0]  lcr_wdata = '0;
   logic        rsr_wr = 1'b0;
   logic [11:0] rd_data;
   logic [7:0]  flags;
   logic [3:0]  rx_status;
   logic [4:0]  count;
   logic        overrun;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string phase = "reset";

   always #2.5 clk = ~clk;

   uart_rx_buffer dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rd_strobe(rd_strobe), .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata), .rsr_wr(rsr_wr),
      .rd_data(rd_data), .flags(flags), .rx_status(rx_status), .count(count),
      .overrun(overrun)
   );

   // behavioural reference
   logic [11:0] m_mem [16];
   int          m_pos, m_cnt;
   bit          m_mode, m_full, m_empty, m_ovr;
   logic [3:0]  m_rsr;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = '0;
         m_pos = 0; m_cnt = 0; m_mode = 0; m_full = 0; m_empty = 1; m_ovr = 0; m_rsr = '0;
      end else begin
         bit flip, acc, pop;
         int old_pos, old_cnt;
         flip = lcr_wr && (lcr_wdata[4] != m_mode);
         old_pos = m_pos; old_cnt = m_cnt;
         m_ovr = rx_valid && !flip && (old_cnt == 16);
         acc = rx_valid && !flip && (old_cnt < 16);
         pop = rd_strobe && !flip && (old_cnt > 0);
         if (rsr_wr) m_rsr = '0;
         else if (rd_strobe) m_rsr = m_mem[old_pos][11:8];
         if (flip) begin
            m_pos = 0; m_cnt = 0; m_empty = 1; m_full = 0;
         end else begin
            if (acc) m_mem[(old_pos + old_cnt) % 16] = rx_data;
            if (pop) m_pos = (old_pos + 1) % 16;
            m_cnt = old_cnt + (acc ? 1 : 0) - (pop ? 1 : 0);
            if (acc && (!m_mode || m_cnt == 16)) m_full = 1;
            else if (rd_strobe) m_full = 0;
            if (acc) m_empty = 0;
            else if (rd_strobe && m_cnt == 0) m_empty = 1;
         end
         if (lcr_wr) m_mode = lcr_wdata[4];
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s) actual=0x%0h expected=0x%0h at %0t", req, phase, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 count", 32'(count), 32'(m_cnt));
         check("R2 flags", 32'(flags), 32'({1'b1, m_full, 1'b0, m_empty, 4'b0}));
         check("R5 rd_data", 32'(rd_data), 32'(m_mem[m_pos]));
         check("R7 status", 32'(rx_status), 32'(m_rsr));
         check("R9 overrun", 32'(overrun), 32'(m_ovr));
      end
   end

   task automatic cyc(bit v, logic [11:0] d, bit r, bit lw, logic [7:0] ld, bit sw);
      rx_valid = v; rx_data = d; rd_strobe = r; lcr_wr = lw; lcr_wdata = ld; rsr_wr = sw;
      @(negedge clk);
      rx_valid = 0; rd_strobe = 0; lcr_wr = 0; rsr_wr = 0;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (%s) actual=timeout expected=finish", phase);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R2 reset state";
      check("R2 reset flags", 32'(flags), 32'h90);
      check("R2 reset count", 32'(count), 32'h0);
      // R3 R4 single-character mode: one byte raises full
      phase = "R3 R4 single char";
      cyc(1, 12'h53A, 0, 0, 8'h00, 0);
      check("R4 full after one", 32'(flags), 32'hC0);
      cyc(1, 12'h011, 0, 0, 8'h00, 0);
      // R7 read loads error bits
      phase = "R7 status load";
      cyc(0, 0, 1, 0, 0, 0);
      check("R7 status 5", 32'(rx_status), 32'h5);
      // R8 non-flip write keeps data, flip flushes with concurrent byte dropped
      phase = "R8 keep mode";
      cyc(0, 0, 0, 1, 8'h03, 0);
      check("R8 nonflip count", 32'(count), 32'h1);
      phase = "R8 flip flush";
      cyc(1, 12'h0FF, 0, 1, 8'h10, 0);
      check("R8 flush count", 32'(count), 32'h0);
      check("R8 flush flags", 32'(flags), 32'h90);
      // R1 R4 fill buffered mode to 16
      phase = "R1 R4 fill";
      for (int i = 0; i < 16; i++) cyc(1, 12'((i << 8) | (8'hA0 + i)), 0, 0, 0, 0);
      check("R4 full at 16", 32'(flags), 32'hC0);
      // R9 overrun
      phase = "R9 overrun";
      rx_valid = 1; rx_data = 12'hEEE;
      @(negedge clk);
      rx_valid = 0;
      check("R9 pulse", 32'(overrun), 32'h1);
      cyc(0, 0, 0, 0, 0, 0);
      check("R9 pulse end", 32'(overrun), 32'h0);
      // R5 drain in order
      phase = "R5 drain";
      for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0, 0);
      check("R5 empty after drain", 32'(flags), 32'h90);
      // R6 stale reads
      phase = "R6 empty read";
      cyc(0, 0, 1, 0, 0, 0);
      cyc(0, 0, 1, 0, 0, 0);
      check("R6 count stays", 32'(count), 32'h0);
      // R1 R10 wrap with concurrent read and receive
      phase = "R1 R10 wrap";
      for (int i = 0; i < 5; i++) cyc(1, 12'(12'h300 + i), 0, 0, 0, 0);
      for (int i = 0; i < 30; i++) cyc(1, 12'(12'h700 + i), 1, 0, 0, 0);
      check("R10 count steady", 32'(count), 32'h5);
      // R7 clear priority over read
      phase = "R7 clear wins";
      cyc(0, 0, 1, 0, 0, 1);
      check("R7 cleared", 32'(rx_status), 32'h0);
      // mixed traffic
      phase = "R1 R4 R8 mixed";
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = $urandom_range(0, 99);
         cyc(k < 55, 12'($urandom), ($urandom_range(0, 99) < 45), k > 96,
             8'($urandom), ($urandom_range(0, 99) < 5));
      end
      summary();
   end
endmodule